// File: doc/BRIEF.md
# Sum-of-Products Fabric with Fixed OR Grouping and Output Feedback

This block is a small programmable sum-of-products fabric. A bank of product-term gates reads a set of literal lines. The literals are the fabric inputs and the fabric's own outputs, fed back into the gates. For every literal, each gate owns two fuses: one on the true line and one on the complemented line. These fuses are the only programmable connections. The OR side is hard-wired: each output sums its own fixed, contiguous group of product terms. Because of that, a configuration is just one fuse row per product term. No sum-term data is stored.

Software writes the fuse rows through a simple write port, one row per write, and then issues a one-time lock. The fabric evaluates combinationally at all times, both before and after the lock. To keep the evaluation free of combinational loops, outputs are evaluated in index order, and a product term of output j can only see feedback from lower-numbered outputs. Any fuse on a feedback line that is not allowed is ignored during evaluation. That includes feedback from the output's own group. The lock raises a configuration-error flag if any such fuse is still intact.

Top module: `pal_fabric`

## Requirements
- R1: After reset every fuse is intact, `locked` and `cfg_err` are 0, and so every output is 0.
- R2: Fuse row layout: for literal i, bit 2i is the true-line fuse and bit 2i+1 is the complement-line fuse. A 1 means intact (connected). Literals 0..N_IN-1 are `in_x`, and literal N_IN+k is `out_y[k]`. With the default parameters a row is 14 bits wide.
- R3: A product term is the AND of all its connected lines. A term with no intact fuse evaluates to 1. A term with both fuses of one literal intact evaluates to 0.
- R4: Output j is the OR of product terms j*P through j*P+P-1, where P is the number of terms per output (2 by default).
- R5: A term in group j may use `out_y[k]` for k < j. The feedback value takes effect in the same cycle, with no register in between.
- R6: An intact fuse on the feedback line of `out_y[k]` with k >= j, in a term of group j, is treated as open during evaluation.
- R7: While unlocked, `pgm_we` with `pgm_addr` below the term count replaces that term's fuse row at the clock edge. A write to a larger address changes nothing.
- R8: `lock_req` sets `locked` at the next clock edge, and `locked` stays set until reset.
- R9: A write made while locked, or in the same cycle as `lock_req`, is ignored.
- R10: `cfg_err` is 0 before the lock. At the locking edge it becomes 1 if and only if some stored row has an intact fuse that R6 ignores. It then holds until reset.
- R11: Once locked, the outputs depend only on `in_x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_we | input | 1 | Fuse row write strobe |
| pgm_addr | input | AW (3) | Product term index to write |
| pgm_row | input | ROW_W (14) | Fuse row data |
| lock_req | input | 1 | One-time lock request |
| in_x | input | N_IN (4) | Fabric inputs |
| out_y | output | N_OUT (3) | Sum-of-products outputs, also fed back |
| locked | output | 1 | Configuration is frozen |
| cfg_err | output | 1 | Lock found an ignored feedback fuse |

## Verification
The bench drives a row write and a lock request in the same cycle. The write targets term 0, and its all-open row would force output 0 high. After the edge, the bench applies an input pattern for which the old row gives 0, so an accepted write would show as a 1 on `out_y[0]`. In the same step it checks that `locked` rose and that `cfg_err` stayed low for a legal configuration.

A second run programs a term with its own-group feedback fuse intact. The bench then checks that the fuse has no effect on the output, and that the lock edge raises `cfg_err`.

// File: rtl/pal_pkg.sv
// Package: shared helpers for the sum-of-products fabric.
// Assumes a fuse row is at most 64 bits wide.
package pal_pkg;

    // Mask of the fuse columns a term of group grp may connect:
    // all input literals plus feedback from outputs below grp.
    function automatic logic [63:0] fb_allow(input int n_in, input int grp);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n_in + grp; i++) begin
            m[2*i]   = 1'b1;
            m[2*i+1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pal_and_term.sv
// Module: one product term. Each literal reaches the gate through a
// true-line fuse (even bit) and a complement-line fuse (odd bit).
// An open fuse removes that line from the AND.
// Assumes fuse bit 2i/2i+1 belong to lit[i].
module pal_and_term #(
    parameter int N_LIT = 7
) (
    input  logic [N_LIT-1:0]   lit,
    input  logic [2*N_LIT-1:0] fuse,
    output logic               prod
);
    logic [N_LIT-1:0] t_ok;
    logic [N_LIT-1:0] c_ok;

    for (genvar i = 0; i < N_LIT; i++) begin : g_lit
        // Each connected line must be high for the term to hold.
        assign t_ok[i] = ~fuse[2*i]   | lit[i];
        assign c_ok[i] = ~fuse[2*i+1] | ~lit[i];
    end

    // AND over every line; no connection at all yields 1.
    assign prod = (&t_ok) & (&c_ok);
endmodule

// File: rtl/pal_or_group.sv
// Module: the hard-wired OR of one output's product terms.
// Forbidden feedback columns (own or later outputs) are masked to open
// before the terms see them, which keeps the fabric free of loops.
// Assumes the caller hands in only the P rows of group GRP.
module pal_or_group #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int P     = 2,
    parameter int GRP   = 0
) (
    input  logic [N_IN-1:0]           in_x,
    input  logic [N_OUT-1:0]          fb,
    input  logic [P*2*(N_IN+N_OUT)-1:0] rows,
    output logic                      sum
);
    localparam int N_LIT = N_IN + N_OUT;
    localparam int ROW_W = 2 * N_LIT;
    localparam logic [63:0] ALLOW = pal_pkg::fb_allow(N_IN, GRP);

    logic [N_LIT-1:0] lit;
    logic [P-1:0]     prods;

    // Literal lines: inputs in the low positions, feedback above.
    assign lit = {fb, in_x};

    for (genvar t = 0; t < P; t++) begin : g_term
        logic [ROW_W-1:0] eff;
        // Drop fuses on feedback lines this group may not read.
        assign eff = rows[t*ROW_W +: ROW_W] & ALLOW[ROW_W-1:0];
        pal_and_term #(.N_LIT(N_LIT)) u_term (
            .lit  (lit),
            .fuse (eff),
            .prod (prods[t])
        );
    end

    // Fixed OR wiring over the group's terms.
    assign sum = |prods;
endmodule

// File: rtl/pal_fuse_store.sv
// Module: fuse row storage with a write port and one-time lock.
// On the locking edge it also records whether any row keeps a fuse
// that evaluation ignores. Reset restores every fuse to intact.
// Assumes synchronous active-low reset.
module pal_fuse_store #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int P     = 2,
    parameter int N_TERM = N_OUT * P,
    parameter int ROW_W  = 2 * (N_IN + N_OUT),
    parameter int AW     = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_we,
    input  logic [AW-1:0]    pgm_addr,
    input  logic [ROW_W-1:0] pgm_row,
    input  logic             lock_req,
    output logic [ROW_W-1:0] rows [N_TERM],
    output logic             locked,
    output logic             cfg_err
);
    logic bad_fuse;
    logic wr_ok;

    // A write lands only while unlocked, in range, and not racing a lock.
    assign wr_ok = pgm_we && !locked && !lock_req &&
                   (32'(pgm_addr) < N_TERM);

    // Scan every row for intact fuses on forbidden feedback columns.
    always_comb begin
        logic [63:0] a;
        bad_fuse = 1'b0;
        for (int t = 0; t < N_TERM; t++) begin
            a = pal_pkg::fb_allow(N_IN, t / P);
            bad_fuse = bad_fuse | (|(rows[t] & ~a[ROW_W-1:0]));
        end
    end

    // Row storage: reset to intact, then accept qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) rows[t] <= '1;
        end else if (wr_ok) begin
            rows[pgm_addr] <= pgm_row;
        end
    end

    // Lock and error flag: set once, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            cfg_err <= 1'b0;
        end else if (lock_req && !locked) begin
            locked  <= 1'b1;
            cfg_err <= bad_fuse;
        end
    end
endmodule

// File: rtl/pal_fabric.sv
// Module: top of the sum-of-products fabric. Outputs are evaluated in
// index order; each group receives a feedback vector holding only the
// outputs below it, passed along a chain of per-group signals.
// Assumes N_TERM = N_OUT*P and ROW_W <= 64.
module pal_fabric #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int P     = 2,
    localparam int N_TERM = N_OUT * P,
    localparam int ROW_W  = 2 * (N_IN + N_OUT),
    localparam int AW     = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_we,
    input  logic [AW-1:0]    pgm_addr,
    input  logic [ROW_W-1:0] pgm_row,
    input  logic             lock_req,
    input  logic [N_IN-1:0]  in_x,
    output logic [N_OUT-1:0] out_y,
    output logic             locked,
    output logic             cfg_err
);
    logic [ROW_W-1:0] fuse_rows [N_TERM];

    pal_fuse_store #(
        .N_IN(N_IN), .N_OUT(N_OUT), .P(P),
        .N_TERM(N_TERM), .ROW_W(ROW_W), .AW(AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_we   (pgm_we),
        .pgm_addr (pgm_addr),
        .pgm_row  (pgm_row),
        .lock_req (lock_req),
        .rows     (fuse_rows),
        .locked   (locked),
        .cfg_err  (cfg_err)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_grp
        logic [N_OUT-1:0]   fb_in;
        logic [N_OUT-1:0]   fb_out;
        logic [P*ROW_W-1:0] grp_rows;
        logic               sum;

        // Feedback available to this group: outputs 0..j-1 only.
        if (j == 0) begin : g_first
            assign fb_in = '0;
        end else begin : g_next
            assign fb_in = g_grp[j-1].fb_out;
        end

        // Gather this group's fixed slice of fuse rows.
        for (genvar t = 0; t < P; t++) begin : g_pack
            assign grp_rows[t*ROW_W +: ROW_W] = fuse_rows[j*P + t];
        end

        pal_or_group #(
            .N_IN(N_IN), .N_OUT(N_OUT), .P(P), .GRP(j)
        ) u_grp (
            .in_x (in_x),
            .fb   (fb_in),
            .rows (grp_rows),
            .sum  (sum)
        );

        // Extend the chain with this group's result.
        always_comb begin
            fb_out    = fb_in;
            fb_out[j] = sum;
        end

        assign out_y[j] = sum;
    end
endmodule

// File: rtl/pal_fabric_chk.sv
// Checker: temporal properties of the fabric, bound to pal_fabric.
module pal_fabric_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int P     = 2,
    localparam int N_TERM = N_OUT * P,
    localparam int ROW_W  = 2 * (N_IN + N_OUT),
    localparam int AW     = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pgm_we,
    input logic [AW-1:0]    pgm_addr,
    input logic [ROW_W-1:0] pgm_row,
    input logic             lock_req,
    input logic [N_IN-1:0]  in_x,
    input logic [N_OUT-1:0] out_y,
    input logic             locked,
    input logic             cfg_err,
    input logic [ROW_W-1:0] fuse_rows [N_TERM]
);
    // R8: the lock never drops without reset.
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R8: a lock request always yields locked next edge.
    p_lock_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> locked);

    // R10: no error flag without a lock.
    p_err_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !cfg_err);

    // R10: the error flag only changes on the locking edge.
    p_err_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_err));

    // R9: stored rows do not change after the lock.
    p_rows_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(fuse_rows[0]) && $stable(fuse_rows[N_TERM-1]));

    // R7: a qualified write is visible in storage after the edge.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_we && !locked && !lock_req && (32'(pgm_addr) < N_TERM))
        |=> fuse_rows[$past(pgm_addr)] == $past(pgm_row));

    // R11: locked fabric with steady inputs holds steady outputs.
    p_out_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked) && $stable(in_x)) |-> $stable(out_y));
endmodule

bind pal_fabric pal_fabric_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .P(P)) u_chk (.*);

// File: tb/pal_fabric_test.sv
`timescale 1ns/100ps
// Bench: scoreboard for pal_fabric with default parameters.
// A driver task queues expected values, a monitor compares them.
module pal_fabric_test;
    localparam real HALF = 2.5;

    typedef struct {
        int         sel;   // 0 out_y, 1 locked, 2 cfg_err
        logic [2:0] exp;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pgm_we = 1'b0;
    logic [2:0]  pgm_addr = '0;
    logic [13:0] pgm_row = '0;
    logic        lock_req = 1'b0;
    logic [3:0]  in_x = '0;
    logic [2:0]  out_y;
    logic        locked;
    logic        cfg_err;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    event  mon_ev;

    always #(HALF) clk = ~clk;

    pal_fabric uut (
        .clk(clk), .rst_n(rst_n), .pgm_we(pgm_we), .pgm_addr(pgm_addr),
        .pgm_row(pgm_row), .lock_req(lock_req), .in_x(in_x),
        .out_y(out_y), .locked(locked), .cfg_err(cfg_err)
    );

    // Monitor: pop one expected item per trigger and compare.
    initial begin
        forever begin
            item_t it;
            logic [2:0] got;
            @(mon_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                case (it.sel)
                    0:       got = out_y;
                    1:       got = {2'b0, locked};
                    default: got = {2'b0, cfg_err};
                endcase
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: sel %0d got %b expected %b (in_x %b)",
                             it.req, it.sel, got, it.exp, in_x);
                end
            end
        end
    end

    // Driver: queue one expectation, then wake the monitor.
    task automatic expect_val(input int sel, input logic [2:0] e, input string r);
        item_t it;
        it.sel = sel; it.exp = e; it.req = r;
        q.push_back(it);
        ->mon_ev;
        #0.1;
    endtask

    // Apply inputs after a falling edge and check outputs mid-phase.
    task automatic apply(input logic [3:0] x, input logic [2:0] e, input string r);
        @(negedge clk);
        in_x = x;
        #1;
        expect_val(0, e, r);
    endtask

    // One write cycle, optionally with a lock request alongside.
    task automatic wr(input logic [2:0] a, input logic [13:0] row, input bit lk);
        @(negedge clk);
        pgm_we = 1'b1; pgm_addr = a; pgm_row = row; lock_req = lk;
        @(negedge clk);
        pgm_we = 1'b0; lock_req = 1'b0;
    endtask

    task automatic do_lock();
        @(negedge clk);
        lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reference for the legal program: y0=x0&x1|~x2, y1=y0&x3, y2=~y1|x0&~x3.
    function automatic logic [2:0] ref_y(input logic [3:0] x);
        logic y0, y1, y2;
        y0 = (x[0] & x[1]) | ~x[2];
        y1 = y0 & x[3];
        y2 = ~y1 | (x[0] & ~x[3]);
        return {y2, y1, y0};
    endfunction

    task automatic sweep(input string r);
        for (int v = 0; v < 16; v++) apply(4'(v), ref_y(4'(v)), r);
    endtask

    initial begin
        do_reset();
        // R1: all fuses intact so every term is 0.
        #1;
        expect_val(1, 3'b000, "R1 locked");
        expect_val(2, 3'b000, "R1 cfg_err");
        apply(4'b0000, 3'b000, "R1 outputs");
        apply(4'b1111, 3'b000, "R1 outputs");

        // R3: an all-open term is 1, forcing output 0 high.
        wr(3'd0, 14'h0000, 1'b0);
        apply(4'b0000, 3'b001, "R3 open term");
        apply(4'b1010, 3'b001, "R3 open term");

        // R2/R4/R5: legal program; y1 reads y0, y2 reads y1.
        wr(3'd0, 14'h0005, 1'b0);   // x0 & x1
        wr(3'd1, 14'h0020, 1'b0);   // ~x2
        wr(3'd2, 14'h0140, 1'b0);   // y0 & x3
        wr(3'd3, 14'h0003, 1'b0);   // x0 & ~x0 : disabled (R3)
        wr(3'd4, 14'h0800, 1'b0);   // ~y1
        wr(3'd5, 14'h0081, 1'b0);   // x0 & ~x3
        sweep("R2 R4 R5 program");

        // R7: out-of-range address changes nothing.
        wr(3'd7, 14'h0000, 1'b0);
        wr(3'd6, 14'h0000, 1'b0);
        sweep("R7 range");

        // R9: write to term 0 in the lock cycle is dropped.
        wr(3'd0, 14'h0000, 1'b1);
        #1;
        expect_val(1, 3'b001, "R8 lock set");
        expect_val(2, 3'b000, "R10 clean lock");
        apply(4'b0100, ref_y(4'b0100), "R9 same-cycle write");

        // R9: write after lock is dropped.
        wr(3'd1, 14'h0000, 1'b0);
        apply(4'b0100, ref_y(4'b0100), "R9 locked write");
        // R11: outputs follow inputs only.
        sweep("R11 locked eval");
        do_lock();
        #1;
        expect_val(1, 3'b001, "R8 sticky");
        expect_val(2, 3'b000, "R10 held");

        // Second run: forbidden feedback fuses.
        do_reset();
        #1;
        expect_val(1, 3'b000, "R1 second reset");
        wr(3'd4, 14'h1001, 1'b0);   // x0 & y2(self)
        wr(3'd0, 14'h0400, 1'b0);   // y1 in group 0 (later)
        // R6: forbidden lines open: y0=1, y1=0, y2=x0.
        apply(4'b0001, 3'b101, "R6 masked feedback");
        apply(4'b0000, 3'b001, "R6 masked feedback");
        #1;
        expect_val(2, 3'b000, "R10 before lock");
        do_lock();
        #1;
        expect_val(2, 3'b001, "R10 error at lock");
        expect_val(1, 3'b001, "R8 second lock");
        apply(4'b1111, 3'b101, "R6 after lock");

        #5;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule